// File: doc/BRIEF.md
# Multi-Channel Serial Port Interrupt Aggregator

This block collects the interrupt causes of several serial channels and condenses them into a single 32-bit status word and one host interrupt line. Each channel has six causes:

- a receive line error;
- a receive time-out;
- receive data at or above its trigger level;
- the transmit holding side going empty;
- a change on the modem inputs;
- a change on the flow-control outputs.

The block keeps a pending flag for each cause. Each flag is released by the host action that belongs to that cause:

- reading the line status;
- draining the receive FIFO;
- reading it down below the trigger;
- loading the transmitter or reading the channel's interrupt status;
- reading the modem status;
- reading the interrupt status.

The host reads the status word to see at a glance which channels need service and why. The lowest byte carries one summary bit per channel. Above it, each channel has a fixed 3-bit slot. The slot reports that channel's most urgent enabled cause. The word is read-only, and the block does not decode any writes to it. The channel count is a parameter of up to eight. Summary bits and slots beyond the channel count are tied to zero.

Top module: `uirq_agg`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `stat_word` is 0 and `host_irq` is 0.
- R2: Bit n of `stat_word` (n below NCH) is the summary of channel n. Bits [10+3n:8+3n] hold the code of channel n. Summary bits NCH to 7 and all slots at or above channel NCH read as 0.
- R3: The cause enable for channel n, cause k is `src_en[6n+k]`. The values of k are: 0 line error, 1 time-out, 2 receive ready, 3 transmit empty, 4 modem input change, 5 output pin change. A channel's code is the enabled pending cause with the lowest k, reported as code k+1. The code is 0 when no enabled cause is pending. Code 7 never appears.
- R4: Receive-ready is pending while the channel's `rx_fill` is greater than or equal to its `rx_trig`. It shows one cycle after the fill level, and it clears once the fill drops below the trigger.
- R5: A `rx_tmo_evt` pulse while the fill is nonzero sets the time-out cause. The cause stays pending while the fill is nonzero, whatever its level, and clears in the cycle after the fill is 0.
- R6: A `line_err_evt` pulse sets the line-error cause. Only `lsr_rd` clears it. `isr_rd` and `msr_rd` leave it pending.
- R7: A rising edge of `tx_empty` sets the transmit-empty cause. A steady high level does not set it again. `tx_load` clears it. `isr_rd` also clears it, but only when the channel's code reads 4 at the time of the read.
- R8: A `modem_in_chg` pulse sets the modem cause. Only `msr_rd` clears it.
- R9: A `pin_out_chg` pulse sets the output pin cause. Only `isr_rd` clears it.
- R10: The summary bit of a channel is 1 exactly when that channel's code is nonzero. Several channels can show their summary bits at the same time.
- R11: `host_irq` equals the OR of the summary bits one clock cycle earlier.
- R12: When a set event and its clearing action arrive in the same cycle, the cause is pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_fill | input | NCH*FILL_W | Receive FIFO fill level per channel |
| rx_trig | input | NCH*FILL_W | Receive trigger level per channel |
| rx_tmo_evt | input | NCH | Receive time-out event pulse |
| line_err_evt | input | NCH | Receive line error event pulse |
| tx_empty | input | NCH | Transmit holding side empty (level) |
| tx_load | input | NCH | Host loaded the transmitter |
| modem_in_chg | input | NCH | Modem input change pulse |
| pin_out_chg | input | NCH | Flow-control output change pulse |
| isr_rd | input | NCH | Host read of the channel interrupt status |
| msr_rd | input | NCH | Host read of the channel modem status |
| lsr_rd | input | NCH | Host read of the channel line status |
| src_en | input | NCH*6 | Cause enables, six per channel |
| stat_word | output | 32 | Read-only interrupt status word |
| host_irq | output | 1 | Combined host interrupt, active high |

## Verification
A table drives sets of pending causes against sets of enables on a rotating channel. It separates a correct priority order from a swapped one. It separates a masked cause from one that leaks through. It also shows whether a code lands in the right slot rather than a neighbouring one. Directed sequences then try each clearing action against the causes it must not touch. They include a transmit-empty cause hidden behind a line error, which tells a code-qualified clear from a blind one. A raise and a clear in the same cycle show whether set wins. Two channels active at once, followed by a simultaneous clear, reveal whether the summary bits merge correctly. They also show whether the host line lags the word by exactly one cycle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int CODE_W  = 3;
    localparam int NSRC    = 6;
    localparam int SLOTS   = 8;
    localparam int WORD_W  = 32;
    localparam int SUM_W   = 8;

    typedef enum logic [CODE_W-1:0] {
        CODE_NONE  = 3'd0,
        CODE_LINE  = 3'd1,
        CODE_TMO   = 3'd2,
        CODE_RXRDY = 3'd3,
        CODE_TXE   = 3'd4,
        CODE_MODEM = 3'd5,
        CODE_PIN   = 3'd6
    } cause_code_e;

    // first member is the MSB: line error sits at bit 0
    typedef struct packed {
        logic pin;
        logic modem;
        logic txe;
        logic rxrdy;
        logic tmo;
        logic line;
    } src_vec_t;

    function automatic cause_code_e pick_cause(input src_vec_t p);
        cause_code_e c;
        if (p.line)       c = CODE_LINE;
        else if (p.tmo)   c = CODE_TMO;
        else if (p.rxrdy) c = CODE_RXRDY;
        else if (p.txe)   c = CODE_TXE;
        else if (p.modem) c = CODE_MODEM;
        else if (p.pin)   c = CODE_PIN;
        else              c = CODE_NONE;
        return c;
    endfunction

endpackage

// File: rtl/uirq_chan_track.sv
module uirq_chan_track
    import uirq_pkg::*;
#(
    parameter int FILL_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FILL_W-1:0] fill,
    input  logic [FILL_W-1:0] trig,
    input  logic              tmo_evt,
    input  logic              line_evt,
    input  logic              tx_empty,
    input  logic              tx_load,
    input  logic              modem_chg,
    input  logic              pin_chg,
    input  logic              isr_rd,
    input  logic              msr_rd,
    input  logic              lsr_rd,
    input  logic              txe_shown,
    output src_vec_t          pend
);

    src_vec_t pend_q;
    logic     tx_prev_q;
    logic     fill_nz;
    logic     at_trig;
    logic     tx_rise;

    assign fill_nz = (fill != '0);
    assign at_trig = (fill >= trig);
    assign tx_rise = tx_empty & ~tx_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            tx_prev_q <= 1'b0;
        end else begin
            tx_prev_q    <= tx_empty;
            pend_q.line  <= line_evt | (pend_q.line & ~lsr_rd);
            pend_q.tmo   <= (tmo_evt | pend_q.tmo) & fill_nz;
            pend_q.rxrdy <= at_trig;
            pend_q.txe   <= tx_rise | (pend_q.txe & ~tx_load & ~(isr_rd & txe_shown));
            pend_q.modem <= modem_chg | (pend_q.modem & ~msr_rd);
            pend_q.pin   <= pin_chg | (pend_q.pin & ~isr_rd);
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
    import uirq_pkg::*;
(
    input  src_vec_t              pend,
    input  logic [NSRC-1:0]       en,
    output logic [CODE_W-1:0]     code,
    output logic                  active
);

    src_vec_t masked;

    always_comb begin
        masked = src_vec_t'(pend & en);
        code   = pick_cause(masked);
        active = |masked;
    end

endmodule

// File: rtl/uirq_word_pack.sv
module uirq_word_pack
    import uirq_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0]        act,
    input  logic [NCH*CODE_W-1:0] codes,
    output logic [WORD_W-1:0]     word
);

    for (genvar b = 0; b < SUM_W; b++) begin : g_sum
        if (b < NCH) begin : g_used
            assign word[b] = act[b];
        end else begin : g_pad
            assign word[b] = 1'b0;
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        if (s < NCH) begin : g_used
            assign word[SUM_W + CODE_W*s +: CODE_W] = codes[CODE_W*s +: CODE_W];
        end else begin : g_pad
            assign word[SUM_W + CODE_W*s +: CODE_W] = '0;
        end
    end

endmodule

// File: rtl/uirq_agg.sv
module uirq_agg
    import uirq_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int FILL_W = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH*FILL_W-1:0] rx_fill,
    input  logic [NCH*FILL_W-1:0] rx_trig,
    input  logic [NCH-1:0]        rx_tmo_evt,
    input  logic [NCH-1:0]        line_err_evt,
    input  logic [NCH-1:0]        tx_empty,
    input  logic [NCH-1:0]        tx_load,
    input  logic [NCH-1:0]        modem_in_chg,
    input  logic [NCH-1:0]        pin_out_chg,
    input  logic [NCH-1:0]        isr_rd,
    input  logic [NCH-1:0]        msr_rd,
    input  logic [NCH-1:0]        lsr_rd,
    input  logic [NCH*NSRC-1:0]   src_en,
    output logic [WORD_W-1:0]     stat_word,
    output logic                  host_irq
);

    localparam int CODES_W = NCH * CODE_W;

    logic [NCH-1:0]     act;
    logic [CODES_W-1:0] codes;
    logic               irq_q;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        src_vec_t          pend;
        logic [CODE_W-1:0] code;
        logic              txe_shown;

        assign txe_shown = (code == CODE_TXE);

        uirq_chan_track #(.FILL_W(FILL_W)) u_track (
            .clk       (clk),
            .rst       (rst),
            .fill      (rx_fill[n*FILL_W +: FILL_W]),
            .trig      (rx_trig[n*FILL_W +: FILL_W]),
            .tmo_evt   (rx_tmo_evt[n]),
            .line_evt  (line_err_evt[n]),
            .tx_empty  (tx_empty[n]),
            .tx_load   (tx_load[n]),
            .modem_chg (modem_in_chg[n]),
            .pin_chg   (pin_out_chg[n]),
            .isr_rd    (isr_rd[n]),
            .msr_rd    (msr_rd[n]),
            .lsr_rd    (lsr_rd[n]),
            .txe_shown (txe_shown),
            .pend      (pend)
        );

        uirq_prio_enc u_enc (
            .pend   (pend),
            .en     (src_en[n*NSRC +: NSRC]),
            .code   (code),
            .active (act[n])
        );

        assign codes[n*CODE_W +: CODE_W] = code;
    end

    uirq_word_pack #(.NCH(NCH)) u_pack (
        .act   (act),
        .codes (codes),
        .word  (stat_word)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |stat_word[NCH-1:0];
    end

    assign host_irq = irq_q;

endmodule

// File: rtl/uirq_agg_chk.sv
module uirq_agg_chk #(
    parameter int NCH    = 4,
    parameter int FILL_W = 7
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NCH*FILL_W-1:0] rx_fill,
    input logic [NCH-1:0]        line_err_evt,
    input logic [NCH-1:0]        modem_in_chg,
    input logic [NCH-1:0]        lsr_rd,
    input logic [NCH-1:0]        msr_rd,
    input logic [31:0]           stat_word,
    input logic                  host_irq
);

    localparam logic [31:0] USED =
        ((32'h1 << NCH) - 32'h1) | (((32'h1 << (3*NCH)) - 32'h1) << 8);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (stat_word == 32'h0 && !host_irq));

    p_pad_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (stat_word & ~USED) == 32'h0);

    p_irq_lag_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (host_irq == $past(|stat_word[NCH-1:0])));

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        p_no_code7_r3: assert property (@(posedge clk) disable iff (rst)
            stat_word[8+3*n +: 3] != 3'd7);

        p_summary_r10: assert property (@(posedge clk) disable iff (rst)
            stat_word[n] == (stat_word[8+3*n +: 3] != 3'd0));

        p_lsr_clear_r6: assert property (@(posedge clk) disable iff (rst)
            (lsr_rd[n] && !line_err_evt[n]) |=> (stat_word[8+3*n +: 3] != 3'd1));

        p_msr_clear_r8: assert property (@(posedge clk) disable iff (rst)
            (msr_rd[n] && !modem_in_chg[n] && !line_err_evt[n] && stat_word[8+3*n +: 3] == 3'd5)
            |=> (stat_word[8+3*n +: 3] != 3'd5));

        p_tmo_drop_r5: assert property (@(posedge clk) disable iff (rst)
            (rx_fill[n*FILL_W +: FILL_W] == '0) |=> (stat_word[8+3*n +: 3] != 3'd2));
    end

endmodule

bind uirq_agg uirq_agg_chk #(.NCH(NCH), .FILL_W(FILL_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_fill      (rx_fill),
    .line_err_evt (line_err_evt),
    .modem_in_chg (modem_in_chg),
    .lsr_rd       (lsr_rd),
    .msr_rd       (msr_rd),
    .stat_word    (stat_word),
    .host_irq     (host_irq)
);

// File: tb/uirq_agg_test.sv
`timescale 1ns/1ps
module uirq_agg_test;

    localparam int NCH    = 4;
    localparam int FILL_W = 7;
    localparam int NVEC   = 12;

    // {pending causes [5:0], enables [5:0], expected code [2:0]}
    // cause bit: 0 line, 1 time-out, 2 rx ready, 3 tx empty, 4 modem, 5 pin
    localparam logic [14:0] VEC [NVEC] = '{
        {6'b111111, 6'b111111, 3'd1},
        {6'b111110, 6'b111111, 3'd2},
        {6'b111100, 6'b111111, 3'd3},
        {6'b111000, 6'b111111, 3'd4},
        {6'b110000, 6'b111111, 3'd5},
        {6'b100000, 6'b111111, 3'd6},
        {6'b111111, 6'b111110, 3'd2},
        {6'b000101, 6'b111110, 3'd3},
        {6'b101000, 6'b110111, 3'd6},
        {6'b000000, 6'b111111, 3'd0},
        {6'b111111, 6'b000000, 3'd0},
        {6'b010010, 6'b111111, 3'd2}
    };

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [NCH*FILL_W-1:0] rx_fill;
    logic [NCH*FILL_W-1:0] rx_trig;
    logic [NCH-1:0]        rx_tmo_evt, line_err_evt, tx_empty, tx_load;
    logic [NCH-1:0]        modem_in_chg, pin_out_chg, isr_rd, msr_rd, lsr_rd;
    logic [NCH*6-1:0]      src_en;
    logic [31:0]           stat_word;
    logic                  host_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    uirq_agg #(.NCH(NCH), .FILL_W(FILL_W)) uut (
        .clk(clk), .rst(rst), .rx_fill(rx_fill), .rx_trig(rx_trig),
        .rx_tmo_evt(rx_tmo_evt), .line_err_evt(line_err_evt),
        .tx_empty(tx_empty), .tx_load(tx_load),
        .modem_in_chg(modem_in_chg), .pin_out_chg(pin_out_chg),
        .isr_rd(isr_rd), .msr_rd(msr_rd), .lsr_rd(lsr_rd),
        .src_en(src_en), .stat_word(stat_word), .host_irq(host_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ew(input int ch, input int code);
        logic [31:0] w = '0;
        if (code != 0) begin
            w[ch] = 1'b1;
            w[8+3*ch +: 3] = code[2:0];
        end
        return w;
    endfunction

    task automatic clear_pulses();
        rx_tmo_evt = '0; line_err_evt = '0; tx_load = '0; modem_in_chg = '0;
        pin_out_chg = '0; isr_rd = '0; msr_rd = '0; lsr_rd = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        clear_pulses();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        clear_pulses();
        tx_empty = '0;
        rx_fill  = '0;
        for (int c = 0; c < NCH; c++) rx_trig[c*FILL_W +: FILL_W] = 7'd5;
        src_en = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_fill(input int ch, input int v);
        rx_fill[ch*FILL_W +: FILL_W] = v[FILL_W-1:0];
    endtask

    task automatic set_trig(input int ch, input int v);
        rx_trig[ch*FILL_W +: FILL_W] = v[FILL_W-1:0];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        clear_pulses();
        tx_empty = '0; rx_fill = '0; rx_trig = '0; src_en = '0;
        @(negedge clk);
        check("R1 word in reset", stat_word, 32'h0);
        check("R1 irq in reset", {31'h0, host_irq}, 32'h0);
        do_reset();
        check("R1 word after reset", stat_word, 32'h0);
        check("R1 irq after reset", {31'h0, host_irq}, 32'h0);

        // priority / masking / slot table (R2, R3, R10, R11)
        for (int i = 0; i < NVEC; i++) begin
            int ch = i % NCH;
            logic [5:0] pend = VEC[i][14:9];
            logic [5:0] en   = VEC[i][8:3];
            int code = int'(VEC[i][2:0]);
            do_reset();
            src_en[ch*6 +: 6] = en;
            if (pend[2])      set_fill(ch, 5);
            else if (pend[1]) set_fill(ch, 1);
            rx_tmo_evt[ch]   = pend[1];
            line_err_evt[ch] = pend[0];
            tx_empty[ch]     = pend[3];
            modem_in_chg[ch] = pend[4];
            pin_out_chg[ch]  = pend[5];
            tick();
            check("R3 R2 table code and slot", stat_word, ew(ch, code));
            tick();
            check("R11 table irq", {31'h0, host_irq}, {31'h0, code != 0});
        end

        // R4 receive ready follows fill against trigger
        do_reset(); src_en = '1;
        set_fill(0, 5); tick();
        check("R4 fill at trigger", stat_word, ew(0, 3));
        set_fill(0, 4); tick();
        check("R4 fill below trigger", stat_word, 32'h0);
        set_trig(0, 2); set_fill(0, 2); tick();
        check("R4 lower trigger", stat_word, ew(0, 3));

        // R5 time-out holds until empty
        do_reset(); src_en = '1;
        set_fill(1, 1); rx_tmo_evt[1] = 1'b1; tick();
        check("R5 timeout set", stat_word, ew(1, 2));
        set_fill(1, 3); tick();
        check("R5 timeout held nonempty", stat_word, ew(1, 2));
        set_fill(1, 0); tick();
        check("R5 timeout cleared on empty", stat_word, 32'h0);

        // R6 line error cleared only by line status read
        do_reset(); src_en = '1;
        line_err_evt[3] = 1'b1; tick();
        check("R6 line set", stat_word, ew(3, 1));
        isr_rd[3] = 1'b1; msr_rd[3] = 1'b1; tick();
        check("R6 other reads ignored", stat_word, ew(3, 1));
        lsr_rd[3] = 1'b1; tick();
        check("R6 lsr read clears", stat_word, 32'h0);

        // R12 set wins over clear
        line_err_evt[3] = 1'b1; lsr_rd[3] = 1'b1; tick();
        check("R12 set and clear together", stat_word, ew(3, 1));
        line_err_evt[3] = 1'b1; lsr_rd[3] = 1'b1; tick();
        check("R12 set and clear while pending", stat_word, ew(3, 1));

        // R8 modem cleared only by modem status read
        do_reset(); src_en = '1;
        modem_in_chg[2] = 1'b1; tick();
        check("R8 modem set", stat_word, ew(2, 5));
        isr_rd[2] = 1'b1; lsr_rd[2] = 1'b1; tick();
        check("R8 other reads ignored", stat_word, ew(2, 5));
        msr_rd[2] = 1'b1; tick();
        check("R8 msr read clears", stat_word, 32'h0);

        // R9 pin change cleared only by interrupt status read
        do_reset(); src_en = '1;
        pin_out_chg[1] = 1'b1; tick();
        check("R9 pin set", stat_word, ew(1, 6));
        msr_rd[1] = 1'b1; lsr_rd[1] = 1'b1; tick();
        check("R9 other reads ignored", stat_word, ew(1, 6));
        isr_rd[1] = 1'b1; tick();
        check("R9 isr read clears", stat_word, 32'h0);

        // R7 transmit empty
        do_reset(); src_en = '1;
        tx_empty[0] = 1'b1; tick();
        check("R7 rise sets", stat_word, ew(0, 4));
        tick();
        check("R7 level holds", stat_word, ew(0, 4));
        line_err_evt[0] = 1'b1; tick();
        check("R7 hidden by line error", stat_word, ew(0, 1));
        isr_rd[0] = 1'b1; tick();
        check("R7 isr read while hidden keeps it", stat_word, ew(0, 1));
        lsr_rd[0] = 1'b1; tick();
        check("R7 visible again", stat_word, ew(0, 4));
        isr_rd[0] = 1'b1; tick();
        check("R7 isr read while shown clears", stat_word, 32'h0);
        tick();
        check("R7 steady level does not reset", stat_word, 32'h0);
        tx_empty[0] = 1'b0; tick();
        tx_empty[0] = 1'b1; tick();
        check("R7 new rise sets", stat_word, ew(0, 4));
        tx_load[0] = 1'b1; tick();
        check("R7 load clears", stat_word, 32'h0);

        // R3 enable masks a pending cause
        do_reset(); src_en = '0;
        line_err_evt[2] = 1'b1; tick();
        check("R3 disabled cause hidden", stat_word, 32'h0);
        tick();
        check("R3 disabled cause no irq", {31'h0, host_irq}, 32'h0);
        src_en[2*6] = 1'b1; tick();
        check("R3 enabling reveals cause", stat_word, ew(2, 1));

        // R10 / R11 two channels, then simultaneous clear
        do_reset(); src_en = '1;
        line_err_evt[0] = 1'b1; modem_in_chg[3] = 1'b1; tick();
        check("R10 two summaries", stat_word, ew(0, 1) | ew(3, 5));
        tick();
        check("R11 irq asserted", {31'h0, host_irq}, 32'h1);
        lsr_rd[0] = 1'b1; msr_rd[3] = 1'b1; tick();
        check("R10 both cleared", stat_word, 32'h0);
        check("R11 irq lags word", {31'h0, host_irq}, 32'h1);
        tick();
        check("R11 irq drops", {31'h0, host_irq}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule